// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes the quotient or the remainder of two 32-bit integers for an integer execution pipeline. Operands are treated as signed or unsigned. A two-bit operation code picks among signed quotient, unsigned quotient, signed remainder and unsigned remainder. The code is the low two bits of the function field of the integer multiply/divide instruction group. Within that group, a function field of 100 through 111 selects division or remainder. The block does not trap. A zero divisor and the single signed overflow case each return a fixed value.

A one-cycle `start` pulse captures the operands, the operation and the destination register index. A signed operation is reduced to magnitudes, runs an unsigned restoring loop that produces one quotient bit per cycle, and has its signs applied as the last iteration completes. The two exceptional cases skip the loop and finish on the next cycle. `done` pulses for one cycle with `result`. `wr_en` qualifies that pulse and stays low when the captured destination index is zero.

Top module: `rv_divrem_unit`

## Requirements
- R1: `op[1]` selects the result kind: 0 gives the quotient and 1 gives the remainder. `op[0]` selects the interpretation: 0 means signed two's complement and 1 means unsigned. The codes are 00 signed quotient, 01 unsigned quotient, 10 signed remainder and 11 unsigned remainder.
- R2: For unsigned operations with a nonzero divisor, `result` is the floor quotient or the remainder of `a` divided by `b`.
- R3: For signed operations with a nonzero divisor, other than the overflow pair, the quotient is rounded toward zero. The remainder carries the sign of the dividend, so a = q*b + r.
- R4: A quotient request with `b` equal to zero returns 0xFFFFFFFF, for both signed and unsigned operations.
- R5: A remainder request with `b` equal to zero returns `a` unchanged, for both signed and unsigned operations.
- R6: A signed quotient of 0x80000000 by 0xFFFFFFFF returns 0x80000000. The signed remainder of the same pair returns 0.
- R7: A zero divisor or the signed overflow pair asserts `done` on the cycle after `start`. `busy` stays low for that operation.
- R8: Any other operation holds `busy` high for 32 cycles starting the cycle after `start`. `done` is then high for exactly one cycle, 33 cycles after `start`, and `busy` and `done` are never high together.
- R9: A `start` pulse that arrives while `busy` or `done` is high is ignored. The running operation completes with its own result and timing.
- R10: `wr_en` is high only in the `done` cycle and only if the `rd` captured at the accepted `start` is nonzero. Changing `rd` after `start` has no effect.
- R11: While `rst_n` is low and after its release, `busy`, `done` and `wr_en` are low until a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation code (R1) |
| a | input | 32 | Dividend |
| b | input | 32 | Divisor |
| rd | input | 5 | Destination register index, captured on start |
| busy | output | 1 | Iteration loop is running |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Selected quotient or remainder, valid with done |
| wr_en | output | 1 | Register write enable, done gated by a nonzero rd |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `op`, `a`, `b` and `rd` are stable in the cycle `start` is high. They also assume that reset is released away from an active request. The iteration invariant, which keeps the partial remainder below the divisor, holds only because a zero divisor never enters the loop. The stimulus drives inputs on the falling clock edge, holds `start` for one cycle, and changes `rd` or issues a second `start` only after the first request has been captured. This exercises the ignore paths without breaking those assumptions.

// File: rtl/rv_divrem_pkg.sv
package rv_divrem_pkg;

  // Bit positions inside the operation code
  localparam int unsigned OP_KIND_BIT = 1;  // 1: remainder, 0: quotient
  localparam int unsigned OP_UNS_BIT  = 0;  // 1: unsigned, 0: signed

  typedef enum logic [1:0] {
    DR_QUO_S = 2'b00,
    DR_QUO_U = 2'b01,
    DR_REM_S = 2'b10,
    DR_REM_U = 2'b11
  } dr_op_e;

  // Context captured when an operation is accepted
  typedef struct packed {
    logic want_rem;
    logic negate;
  } dr_ctx_t;

endpackage

// File: rtl/rv_divrem_special.sv
module rv_divrem_special #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             hit,
  output logic [WIDTH-1:0] value
);
  import rv_divrem_pkg::*;

  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic want_rem;
  logic is_uns;
  logic zero_div;
  logic ovf;

  always_comb begin
    want_rem = op[OP_KIND_BIT];
    is_uns   = op[OP_UNS_BIT];
    zero_div = (b == '0);
    ovf      = !is_uns && (a == MOST_NEG) && (b == '1);
    hit      = zero_div || ovf;
    if (zero_div) begin
      value = want_rem ? a : '1;
    end else begin
      value = want_rem ? '0 : a;
    end
  end

endmodule

// File: rtl/rv_divrem_mag.sv
module rv_divrem_mag #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val,
  input  logic             signed_en,
  output logic [WIDTH-1:0] mag,
  output logic             neg
);

  always_comb begin
    neg = signed_en && val[WIDTH-1];
    mag = neg ? ('0 - val) : val;
  end

endmodule

// File: rtl/rv_divrem_iter.sv
module rv_divrem_iter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quo_nxt,
  output logic [WIDTH-1:0] rem_nxt,
  output logic             last
);

  localparam int unsigned CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] quo_q, rem_q, div_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   diff;
  logic             fits;

  // next-state for one restoring step
  always_comb begin
    shifted = {rem_q, quo_q[WIDTH-1]};
    diff    = shifted - {1'b0, div_q};
    fits    = (shifted >= {1'b0, div_q});
    rem_nxt = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
    quo_nxt = {quo_q[WIDTH-2:0], fits};
    last    = (cnt_q == CNT_LAST);
    if (load) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || step) begin
      cnt_q <= cnt_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (load) begin
      quo_q <= dividend;
      rem_q <= '0;
      div_q <= divisor;
    end else if (step) begin
      quo_q <= quo_nxt;
      rem_q <= rem_nxt;
    end
  end

  assert_rem_below_div_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q < div_q));

  assert_load_not_running_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !load);

endmodule

// File: rtl/rv_divrem_unit.sv
module rv_divrem_unit #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [IDX_W-1:0] rd,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             wr_en
);
  import rv_divrem_pkg::*;

  logic             accept;
  logic             sp_hit;
  logic [WIDTH-1:0] sp_val;
  logic [WIDTH-1:0] opnd [2];
  logic [WIDTH-1:0] mag  [2];
  logic             neg  [2];
  logic             signed_op;
  logic [WIDTH-1:0] quo_nxt, rem_nxt;
  logic             last;
  logic [WIDTH-1:0] raw, fixed;

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [WIDTH-1:0] res_q, res_d;
  logic [IDX_W-1:0] rd_q;
  dr_ctx_t          ctx_q, ctx_d;

  assign accept    = start && !busy_q && !done_q;
  assign signed_op = !op[OP_UNS_BIT];
  assign opnd[0]   = a;
  assign opnd[1]   = b;

  rv_divrem_special #(.WIDTH(WIDTH)) u_special (
    .op(op), .a(a), .b(b), .hit(sp_hit), .value(sp_val)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_mag
    rv_divrem_mag #(.WIDTH(WIDTH)) u_mag (
      .val(opnd[gi]), .signed_en(signed_op), .mag(mag[gi]), .neg(neg[gi])
    );
  end

  rv_divrem_iter #(.WIDTH(WIDTH)) u_iter (
    .clk(clk), .rst_n(rst_n),
    .load(accept && !sp_hit), .step(busy_q),
    .dividend(mag[0]), .divisor(mag[1]),
    .quo_nxt(quo_nxt), .rem_nxt(rem_nxt), .last(last)
  );

  // next-state
  always_comb begin
    ctx_d.want_rem = op[OP_KIND_BIT];
    ctx_d.negate   = op[OP_KIND_BIT] ? neg[0] : (neg[0] ^ neg[1]);
    raw   = ctx_q.want_rem ? rem_nxt : quo_nxt;
    fixed = ctx_q.negate ? ('0 - raw) : raw;

    busy_d = busy_q;
    done_d = 1'b0;
    res_d  = res_q;
    if (accept) begin
      if (sp_hit) begin
        done_d = 1'b1;
        res_d  = sp_val;
      end else begin
        busy_d = 1'b1;
      end
    end else if (busy_q && last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      res_d  = fixed;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept) begin
        rd_q <= rd;
      end
    end
  end

  // data registers
  always_ff @(posedge clk) begin
    if (accept) begin
      ctx_q <= ctx_d;
    end
    if (done_d) begin
      res_q <= res_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
  assign wr_en  = done_q && (rd_q != '0);

  assert_done_pulse_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_done_excl_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_busy_from_start_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_special_fast_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sp_hit) |=> (done && !busy));

  assert_rd_held_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |=> $stable(rd_q));

  assert_wr_only_done_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

endmodule

// File: tb/sim_rv_divrem_unit.sv
module sim_rv_divrem_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  localparam int LAT_LOOP = 33;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [31:0] a, b;
  logic [4:0]  rd;
  logic        busy, done, wr_en;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  // {op, a, b}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'b00, 32'd20,        32'd3},
    {2'b00, 32'hFFFFFFEC,  32'd3},
    {2'b00, 32'd20,        32'hFFFFFFFD},
    {2'b00, 32'hFFFFFFEC,  32'hFFFFFFFD},
    {2'b10, 32'hFFFFFFEC,  32'd3},
    {2'b10, 32'd20,        32'hFFFFFFFD},
    {2'b01, 32'hFFFFFFEC,  32'd3},
    {2'b11, 32'hFFFFFFEC,  32'd3},
    {2'b00, 32'd5,         32'd0},
    {2'b01, 32'd5,         32'd0},
    {2'b10, 32'hFFFFFFF0,  32'd0},
    {2'b11, 32'd1234,      32'd0},
    {2'b00, 32'h80000000,  32'hFFFFFFFF},
    {2'b10, 32'h80000000,  32'hFFFFFFFF},
    {2'b01, 32'h80000000,  32'hFFFFFFFF},
    {2'b10, 32'h80000000,  32'd2},
    {2'b01, 32'hFFFFFFFF,  32'd1},
    {2'b11, 32'd3,         32'd20}
  };

  rv_divrem_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b), .rd(rd),
    .busy(busy), .done(done), .result(result), .wr_en(wr_en)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    if (y == 32'd0) return o[1] ? x : 32'hFFFFFFFF;
    if (!o[0] && x == 32'h80000000 && y == 32'hFFFFFFFF) return o[1] ? 32'd0 : 32'h80000000;
    if (o[0]) return o[1] ? (x % y) : (x / y);
    return o[1] ? 32'($signed(x) % $signed(y)) : 32'($signed(x) / $signed(y));
  endfunction

  function automatic bit is_special(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
    return (y == 32'd0) || (!o[0] && x == 32'h80000000 && y == 32'hFFFFFFFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y, input logic [4:0] r);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y; rd = r;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input int n0, output int n, output logic [31:0] res, output logic we);
    n = n0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    res = result;
    we  = wr_en;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] res;
    logic we;
    logic b1;
    string tag;
    start = 1'b0; op = 2'b00; a = '0; b = '0; rd = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", 32'(busy), 32'd0);
    chk("R11 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 done after reset", 32'(done), 32'd0);
    chk("R11 wr_en after reset", 32'(wr_en), 32'd0);

    // table walk: R1 encodings with R2..R6 values, R7/R8 timing
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  vo;
      logic [31:0] va, vb;
      bit sp;
      vo = VEC[i][65:64]; va = VEC[i][63:32]; vb = VEC[i][31:0];
      sp = is_special(vo, va, vb);
      issue(vo, va, vb, 5'(i + 1));
      b1 = busy;
      collect(1, n, res, we);
      if (vb == 0) tag = vo[1] ? "R1,R5" : "R1,R4";
      else if (sp) tag = "R1,R6";
      else tag = vo[0] ? "R1,R2" : "R1,R3";
      chk(tag, res, model(vo, va, vb));
      chk(sp ? "R7 latency" : "R8 latency", 32'(n), sp ? 32'd1 : 32'(LAT_LOOP));
      chk(sp ? "R7 busy" : "R8 busy", 32'(b1), sp ? 32'd0 : 32'd1);
      chk("R10 wr_en nonzero rd", 32'(we), 32'd1);
      @(negedge clk);
      chk("R8 done one cycle", 32'(done), 32'd0);
    end

    // R9: start while busy is ignored
    issue(2'b01, 32'd100, 32'd7, 5'd3);
    @(negedge clk);
    start = 1'b1; op = 2'b11; a = 32'd999; b = 32'd0; rd = 5'd0;
    @(negedge clk);
    start = 1'b0;
    collect(3, n, res, we);
    chk("R9 result", res, 32'd14);
    chk("R9 latency", 32'(n), 32'(LAT_LOOP));
    chk("R9 rd kept", 32'(we), 32'd1);

    // R9: start during the done cycle is ignored
    issue(2'b00, 32'd9, 32'd0, 5'd4);
    start = 1'b1; op = 2'b01; a = 32'd50; b = 32'd5; rd = 5'd6;
    chk("R9 done visible", 32'(done), 32'd1);
    @(negedge clk);
    start = 1'b0;
    chk("R9 no restart busy", 32'(busy), 32'd0);
    chk("R9 no second done", 32'(done), 32'd0);

    // R10: rd of zero suppresses the write
    issue(2'b01, 32'd40, 32'd8, 5'd0);
    collect(1, n, res, we);
    chk("R10 done with rd0", 32'(done), 32'd1);
    chk("R10 wr_en with rd0", 32'(we), 32'd0);
    chk("R10 result with rd0", res, 32'd5);

    // R10: rd changed after start has no effect
    issue(2'b10, 32'hFFFFFFF9, 32'd2, 5'd9);
    rd = 5'd0;
    collect(1, n, res, we);
    chk("R10 rd after start", 32'(we), 32'd1);
    chk("R3 signed rem", res, 32'hFFFFFFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule